// File: doc/BRIEF.md
# Three-Phase Sine-Triangle Gate Modulator with Deadtime

This block turns three normalized phase references into six inverter gate commands. A single symmetric triangle carrier is shared by all phases. An up/down counter with a programmable step size builds it, and the counter moves only on an update tick that comes once every `TICK_DIV` clocks. The carrier and the references use the same signed fixed-point scale, in which `2^FRAC` stands for +1.0. Each reference is clamped to the range -1.0 to +1.0 before it is compared with the carrier.

For each phase, the high-side command is true while the clamped reference is strictly greater than the carrier. The low-side command is the complement. Each gate then passes through its own turn-on delay cell, so a switch turns on only after a programmable number of clocks and turns off at once. A one-clock sample strobe marks each time the carrier reaches its positive peak. An analog front end can use it to take readings well away from switching edges.

Enable, stop and fault act as plain level controls. Any of them drives all six gates low in the same clock cycle. Dropping enable also restarts the carrier at its minimum, counting upward. The references, step and deadtime are plain level inputs that are sampled continuously. There is no handshake, so no back-pressure applies.

Top module: `stp_spwm_gen`

## Requirements
- R1: With step 4096 (FRAC=14, TICK_DIV=20), the carrier climbs from -16384 to +16384 and back in steps of `step_i`, one step per 20 clocks, and is clamped at both ends. Consecutive sample strobes are therefore 320 clocks apart.
- R2: While `enable_i` is low, the carrier is held at -1.0 with upward direction and the tick divider is cleared. After `enable_i` rises, the first peak strobe is seen 8*20 = 160 clocks later for step 4096.
- R3: `sample_o` is high for exactly one clock each time the carrier reaches +1.0. It is never high unless `enable_i` was high in the previous cycle.
- R4: A reference above +1.0 acts as +1.0 and one below -1.0 acts as -1.0. For example, a reference of +32000 still gives the low-side gate 20 clocks per period, minus the deadtime loss.
- R5: The high-side command of a phase is true while the clamped reference is strictly greater than the carrier. The low-side command is its complement. Over one carrier period of 16 levels, each level where this holds adds 20 clocks of high-side command.
- R6: A gate output rises `deadtime_i`+1 clocks after its command rises and falls in the same cycle as its command. A gate never rises in a cycle directly after a cycle in which its partner gate was high.
- R7: The high-side and low-side gates of one phase are never high together.
- R8: While `enable_i` is low, or `stop_i` or `fault_i` is high, all six gates are low in that same cycle. After release, the gates return to their normal pattern.
- R9: With `step_i` = 0, the carrier stays where it is and no sample strobe is produced. With the carrier held at -1.0, a reference of 0 keeps the high-side gate on permanently and the low-side gate off.
- R10: During reset all gates and the sample strobe are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Modulator run; low restarts the carrier and blanks gates |
| stop_i | input | 1 | Blanks all gates while high |
| fault_i | input | 1 | Blanks all gates while high |
| step_i | input | STEP_W | Carrier increment per update tick (unsigned) |
| deadtime_i | input | DT_W | Extra turn-on delay in clocks |
| ref_a_i | input | REF_W | Phase A reference, signed, 2^FRAC = +1.0 |
| ref_b_i | input | REF_W | Phase B reference, signed |
| ref_c_i | input | REF_W | Phase C reference, signed |
| gate_hi_o | output | 3 | High-side gates, bit 0 = phase A, bit 2 = phase C |
| gate_lo_o | output | 3 | Low-side gates, same bit order |
| sample_o | output | 1 | One-clock strobe at the carrier peak |

## Verification
The comparator and deadtime path is driven with reference triples that sit between carrier levels, exactly on a level, at full scale and far past full scale, under deadtimes of 0, 3 and 10 clocks. Counting gate-high clocks over one full period separates four faults: a comparison with the wrong strictness, a missing clamp, a wrong deadtime loss and a phase wired to the wrong reference. Strobe spacing after a fresh enable and between peaks checks the carrier's start point, step and turning points. Blanking tests with fault, stop and enable show that gate blanking takes effect in the same cycle and that the gates recover cleanly. A zero step shows that the counter truly holds its value.

// File: rtl/stp_pkg.sv
package stp_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/stp_tick_gen.sv
module stp_tick_gen #(
  parameter int TICK_DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/stp_carrier.sv
module stp_carrier
  import stp_pkg::*;
#(
  parameter int FRAC   = 14,
  parameter int STEP_W = FRAC + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run_i,
  input  logic                   tick_i,
  input  logic [STEP_W-1:0]      step_i,
  output logic signed [FRAC+1:0] carrier_o,
  output logic                   peak_o
);
  localparam int CAR_W = FRAC + 2;
  localparam int EW    = CAR_W + 1;
  localparam logic signed [EW-1:0] TOP_E = EW'(1 << FRAC);
  localparam logic signed [EW-1:0] BOT_E = -TOP_E;

  logic signed [CAR_W-1:0] car_q;
  dir_e                    dir_q;
  logic                    peak_q;
  logic signed [EW-1:0]    car_x, step_x, up_sum, dn_sum;

  always_comb begin
    car_x  = EW'(car_q);
    step_x = EW'(step_i);
    up_sum = car_x + step_x;
    dn_sum = car_x - step_x;
  end

  // Counter restarts at the bottom, heading up, whenever the modulator is idle.
  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      car_q  <= BOT_E[CAR_W-1:0];
      dir_q  <= DIR_UP;
      peak_q <= 1'b0;
    end else begin
      peak_q <= 1'b0;
      if (tick_i) begin
        if (dir_q == DIR_UP) begin
          if (up_sum >= TOP_E) begin
            car_q  <= TOP_E[CAR_W-1:0];
            dir_q  <= DIR_DOWN;
            peak_q <= 1'b1;
          end else begin
            car_q <= up_sum[CAR_W-1:0];
          end
        end else begin
          if (dn_sum <= BOT_E) begin
            car_q <= BOT_E[CAR_W-1:0];
            dir_q <= DIR_UP;
          end else begin
            car_q <= dn_sum[CAR_W-1:0];
          end
        end
      end
    end
  end

  assign carrier_o = car_q;
  assign peak_o    = peak_q;
endmodule

// File: rtl/stp_deadtime.sv
module stp_deadtime #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            cmd_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            gate_o
);
  logic            prev_q;
  logic [DT_W-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      prev_q <= 1'b0;
      wait_q <= '0;
    end else begin
      prev_q <= cmd_i;
      if (cmd_i && !prev_q) begin
        wait_q <= dt_i;
      end else if (wait_q != '0) begin
        wait_q <= wait_q - DT_W'(1);
      end
    end
  end

  // Turn-off follows the command at once; turn-on waits for the countdown.
  assign gate_o = en_i && cmd_i && prev_q && (wait_q == '0);
endmodule

// File: rtl/stp_phase.sv
module stp_phase #(
  parameter int FRAC  = 14,
  parameter int REF_W = 16,
  parameter int DT_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run_i,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic signed [FRAC+1:0] carrier_i,
  input  logic [DT_W-1:0]        dt_i,
  output logic                   hi_o,
  output logic                   lo_o
);
  localparam int CAR_W = FRAC + 2;
  localparam int MW    = ((REF_W > CAR_W) ? REF_W : CAR_W) + 1;
  localparam logic signed [MW-1:0] TOP_M = MW'(1 << FRAC);
  localparam logic signed [MW-1:0] BOT_M = -TOP_M;

  logic signed [MW-1:0] ref_x, ref_sat, car_x;
  logic                 above;
  logic                 cmd_hi_q, cmd_lo_q;

  always_comb begin
    ref_x = MW'(ref_i);
    car_x = MW'(carrier_i);
    if (ref_x > TOP_M) begin
      ref_sat = TOP_M;
    end else if (ref_x < BOT_M) begin
      ref_sat = BOT_M;
    end else begin
      ref_sat = ref_x;
    end
    above = ref_sat > car_x;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_hi_q <= 1'b0;
      cmd_lo_q <= 1'b0;
    end else begin
      cmd_hi_q <= run_i && above;
      cmd_lo_q <= run_i && !above;
    end
  end

  stp_deadtime #(.DT_W(DT_W)) u_dt_hi (
    .clk(clk), .rst_n(rst_n), .en_i(run_i), .cmd_i(cmd_hi_q), .dt_i(dt_i), .gate_o(hi_o)
  );

  stp_deadtime #(.DT_W(DT_W)) u_dt_lo (
    .clk(clk), .rst_n(rst_n), .en_i(run_i), .cmd_i(cmd_lo_q), .dt_i(dt_i), .gate_o(lo_o)
  );
endmodule

// File: rtl/stp_spwm_gen.sv
module stp_spwm_gen #(
  parameter int FRAC     = 14,
  parameter int REF_W    = 16,
  parameter int STEP_W   = FRAC + 1,
  parameter int DT_W     = 8,
  parameter int TICK_DIV = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable_i,
  input  logic                    stop_i,
  input  logic                    fault_i,
  input  logic [STEP_W-1:0]       step_i,
  input  logic [DT_W-1:0]         deadtime_i,
  input  logic signed [REF_W-1:0] ref_a_i,
  input  logic signed [REF_W-1:0] ref_b_i,
  input  logic signed [REF_W-1:0] ref_c_i,
  output logic [2:0]              gate_hi_o,
  output logic [2:0]              gate_lo_o,
  output logic                    sample_o
);
  localparam int PHASES = 3;
  localparam int CAR_W  = FRAC + 2;

  logic                    gates_ok;
  logic                    tick;
  logic signed [CAR_W-1:0] carrier;
  logic signed [REF_W-1:0] refs [PHASES];

  assign gates_ok = enable_i && !stop_i && !fault_i;
  assign refs[0]  = ref_a_i;
  assign refs[1]  = ref_b_i;
  assign refs[2]  = ref_c_i;

  stp_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run_i(enable_i), .tick_o(tick)
  );

  stp_carrier #(.FRAC(FRAC), .STEP_W(STEP_W)) u_car (
    .clk(clk), .rst_n(rst_n), .run_i(enable_i), .tick_i(tick),
    .step_i(step_i), .carrier_o(carrier), .peak_o(sample_o)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    stp_phase #(.FRAC(FRAC), .REF_W(REF_W), .DT_W(DT_W)) u_ph (
      .clk(clk), .rst_n(rst_n), .run_i(gates_ok), .ref_i(refs[p]),
      .carrier_i(carrier), .dt_i(deadtime_i),
      .hi_o(gate_hi_o[p]), .lo_o(gate_lo_o[p])
    );
  end
endmodule

// File: rtl/stp_spwm_chk.sv
module stp_spwm_chk #(
  parameter int STEP_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable_i,
  input logic              stop_i,
  input logic              fault_i,
  input logic [STEP_W-1:0] step_i,
  input logic [2:0]        gate_hi_o,
  input logic [2:0]        gate_lo_o,
  input logic              sample_o
);
  assert_gates_blanked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i || stop_i || fault_i) |-> (gate_hi_o == 3'b000 && gate_lo_o == 3'b000))
    else $error("gates active while blanked");

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |=> !sample_o)
    else $error("sample strobe longer than one clock");

  assert_strobe_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> $past(enable_i))
    else $error("sample strobe without enable");

  assert_step_zero_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step_i) == '0) |-> !sample_o)
    else $error("strobe with zero step");

  for (genvar p = 0; p < 3; p++) begin : g_ph
    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi_o[p] && gate_lo_o[p]))
      else $error("shoot-through on phase %0d", p);

    assert_hi_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi_o[p]) |-> !$past(gate_lo_o[p]))
      else $error("high side rose without gap on phase %0d", p);

    assert_lo_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_lo_o[p]) |-> !$past(gate_hi_o[p]))
      else $error("low side rose without gap on phase %0d", p);
  end
endmodule

bind stp_spwm_gen stp_spwm_chk #(.STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .stop_i(stop_i), .fault_i(fault_i),
  .step_i(step_i), .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o), .sample_o(sample_o)
);

// File: tb/sim_stp_spwm_gen.sv
module sim_stp_spwm_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 320;
  localparam int NV         = 4;
  // refs a,b,c ; deadtime ; expected hi/lo clocks per period for a,b,c
  localparam int TBL [NV][10] = '{
    '{0,      5000,  -5000,  3,  136, 176, 216, 96,  96,  216},
    '{32000,  -32000, 8193,  3,  296, 16,  0,   320, 256, 56},
    '{16384,  0,      -5000, 0,  299, 19,  139, 179, 99,  219},
    '{5000,   8193,  -32768, 10, 209, 89,  249, 49,  0,   320}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, stop = 1'b0, fault = 1'b0;
  logic [14:0] step = 15'd4096;
  logic [7:0]  dt = 8'd3;
  logic signed [15:0] ra = '0, rb = '0, rc = '0;
  logic [2:0] ghi, glo;
  logic smp;

  int checks = 0, errors = 0;
  int hi_cnt [3];
  int lo_cnt [3];
  int ovl = 0, smp_cnt = 0, n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stp_spwm_gen u0 (
    .clk(clk), .rst_n(rst_n), .enable_i(enable), .stop_i(stop), .fault_i(fault),
    .step_i(step), .deadtime_i(dt), .ref_a_i(ra), .ref_b_i(rb), .ref_c_i(rc),
    .gate_hi_o(ghi), .gate_lo_o(glo), .sample_o(smp)
  );

  task automatic chk(input string tag, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic run_window(input int len);
    for (int p = 0; p < 3; p++) begin
      hi_cnt[p] = 0;
      lo_cnt[p] = 0;
    end
    ovl = 0;
    smp_cnt = 0;
    repeat (len) begin
      @(posedge clk);
      @(negedge clk);
      for (int p = 0; p < 3; p++) begin
        if (ghi[p]) hi_cnt[p]++;
        if (glo[p]) lo_cnt[p]++;
      end
      if ((ghi & glo) != 3'b000) ovl++;
      if (smp) smp_cnt++;
    end
  endtask

  task automatic wait_sample(output int cnt);
    cnt = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      cnt++;
    end while (!smp && cnt < 2000);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset gates", int'({ghi, glo}), 0);
    chk("R10 reset sample", int'(smp), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Carrier start point, strobe width and period.
    enable = 1'b1;
    wait_sample(n);
    chk("R2 first peak after enable", n, 160);
    @(posedge clk);
    @(negedge clk);
    chk("R3 strobe one clock", int'(smp), 0);
    wait_sample(n);
    chk("R1 peak-to-peak clocks", n + 1, 320);

    // Vector table: duty counts per phase over one full period.
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      ra = 16'(TBL[v][0]);
      rb = 16'(TBL[v][1]);
      rc = 16'(TBL[v][2]);
      dt = 8'(TBL[v][3]);
      wait_sample(n);
      wait_sample(n);
      run_window(WIN);
      for (int p = 0; p < 3; p++) begin
        chk($sformatf("R4/R5/R6 vec %0d phase %0d hi", v, p), hi_cnt[p], TBL[v][4 + 2*p]);
        chk($sformatf("R4/R5/R6 vec %0d phase %0d lo", v, p), lo_cnt[p], TBL[v][5 + 2*p]);
      end
      chk($sformatf("R7 vec %0d overlap cycles", v), ovl, 0);
      chk($sformatf("R3 vec %0d strobes per period", v), smp_cnt, 1);
    end

    // Fault blanking and recovery.
    @(negedge clk);
    ra = 16'sd0; rb = 16'sd5000; rc = -16'sd5000; dt = 8'd3;
    wait_sample(n);
    wait_sample(n);
    fault = 1'b1;
    #1;
    chk("R8 fault blanks same cycle", int'({ghi, glo}), 0);
    run_window(30);
    chk("R8 fault hold hi", hi_cnt[0] + hi_cnt[1] + hi_cnt[2], 0);
    chk("R8 fault hold lo", lo_cnt[0] + lo_cnt[1] + lo_cnt[2], 0);
    fault = 1'b0;
    wait_sample(n);
    wait_sample(n);
    run_window(WIN);
    chk("R8 resume phase a hi", hi_cnt[0], 136);
    chk("R8 resume phase a lo", lo_cnt[0], 176);

    // Stop blanking.
    stop = 1'b1;
    #1;
    chk("R8 stop blanks same cycle", int'({ghi, glo}), 0);
    run_window(25);
    chk("R8 stop hold", hi_cnt[0] + lo_cnt[0] + hi_cnt[1] + lo_cnt[1] + hi_cnt[2] + lo_cnt[2], 0);
    stop = 1'b0;

    // Enable drop blanks and restarts the carrier at its minimum.
    repeat (37) @(negedge clk);
    enable = 1'b0;
    #1;
    chk("R8 enable low blanks same cycle", int'({ghi, glo}), 0);
    repeat (5) @(negedge clk);
    enable = 1'b1;
    wait_sample(n);
    chk("R2 restart peak after re-enable", n, 160);

    // Zero step: carrier frozen at the minimum.
    @(negedge clk);
    enable = 1'b0;
    step = '0;
    ra = 16'sd0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    repeat (50) @(negedge clk);
    run_window(300);
    chk("R9 frozen carrier hi on", hi_cnt[0], 300);
    chk("R9 frozen carrier lo off", lo_cnt[0], 0);
    chk("R9 no strobe with zero step", smp_cnt, 0);

    finish_run();
  end
endmodule